// File: doc/BRIEF.md
# UART Auto-Baud Rate Detector

This block measures the bit time of an incoming serial line while the far end sends an alternating sync character (0x55, sent least significant bit first, framed by a start bit and a stop bit). Once armed, it waits for the first falling edge on the synchronized receive level. From then on it counts enabled cycles of a timing clock between consecutive falling edges. In a 0x55 frame every falling edge is two bit times after the previous one, so each finished span gives half its tick count as the measured bit interval.

Each finished span sets a sticky done flag. Software, or the receive logic, clears the flag before the next falling edge. The frame holds four such spans. On the fourth, the detector writes the last measured bit time into the clock-divider register it holds and drops its own enable. If the tick counter passes its maximum before the next falling edge, detection stops at once. An error flag is then raised together with done, and the divider keeps its earlier value. The timing-clock enable input lets the integrator count either every protocol-clock cycle or only the cycles of a slower divided clock.

Top module: `abr_detector`

## Requirements
- R1: A one-cycle pulse on `arm` while the detector is idle sets `en` at the next clock edge. The first falling edge of `rx` seen while `en` is high starts the measurement and does not set `done`.
- R2: Each later falling edge sets `done` at the clock edge that ends the cycle in which `rx` is first low. At the same edge `ival` is loaded with floor(N/2). N is the number of cycles with `tick` high, counted from the cycle of the previous falling edge up to the cycle before the current one.
- R3: `done` stays high until a cycle with `done_clr` high. If a set event and a clear happen in the same cycle, the set wins.
- R4: On the fourth measurement of one detection, `en` falls at the same edge that sets `done`. At that edge `div_out` is loaded with `ival`'s new value, zero-extended.
- R5: If `tick` is high while the counter holds its all-ones value and no falling edge occurs, `done` and `err` both set at that edge and `en` falls. `div_out` and `ival` keep their values.
- R6: `err` stays high until a cycle with `err_clr` or `done_clr` high. Clearing `err` alone leaves `done` set.
- R7: A cycle with `ival_zero` high clears `ival` to 0, unless a measurement loads it in that same cycle.
- R8: Cycles with `tick` low add nothing to the span count.
- R9: `irq` is high exactly when both `done` and `ie` are high.
- R10: While `en` is low, falling edges on `rx` change neither `done`, `ival` nor `div_out`.
- R11: A cycle with `div_wr` high loads `div_wdata` into `div_out`, unless a fourth-measurement write-back happens in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx | input | 1 | Synchronized receive line level |
| tick | input | 1 | Timing-clock enable; counts only when high |
| arm | input | 1 | Pulse that starts a detection |
| ie | input | 1 | Interrupt enable for done |
| done_clr | input | 1 | Clears done and err |
| err_clr | input | 1 | Clears err |
| ival_zero | input | 1 | Clears the measured interval |
| div_wr | input | 1 | Software write strobe for the divider |
| div_wdata | input | DIV_W (10) | Software divider value |
| en | output | 1 | Detection enabled |
| ival | output | CNT_W-1 (9) | Last measured bit interval, in ticks |
| div_out | output | DIV_W (10) | Current clock-divider value |
| done | output | 1 | Sticky measurement-done flag |
| err | output | 1 | Sticky counter-overrun flag |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check on every cycle the relations between internal events and the flags that follow them. These are: an overrun yields err, done and a dropped enable one edge later; the divider and interval stay fixed across an overrun; the write-back at the fourth measurement matches the new interval; the flags are sticky; and done cannot rise while disabled. What the assertions cannot show is the measured values themselves. That covers the halving of the span, the count under a gated tick, the count of four spans per frame, and the values left behind after software clears. The bench scenarios show these by sending sync frames at several bit lengths and tick rates and comparing each done event against a queue of expected results.

// File: rtl/abr_pkg.sv
`timescale 1ns/1ps
package abr_pkg;
  typedef enum logic [1:0] {
    ABR_OFF  = 2'd0,
    ABR_HUNT = 2'd1,
    ABR_MEAS = 2'd2
  } abr_state_e;
endpackage

// File: rtl/abr_fall_detect.sv
`timescale 1ns/1ps
module abr_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic rx,
  output logic fall
);
  logic rx_q;

  // idle line is high, so reset the history to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_q <= 1'b1;
    else        rx_q <= rx;
  end

  assign fall = rx_q & ~rx;
endmodule

// File: rtl/abr_tick_timer.sv
`timescale 1ns/1ps
module abr_tick_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  // overrun: one more tick would not fit and no edge closes the span
  assign ovf = run & ~restart & tick & (cnt == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt <= '0;
    else if (restart)                 cnt <= {{(CNT_W-1){1'b0}}, tick};
    else if (!run)                    cnt <= '0;
    else if (tick && cnt != CNT_MAX)  cnt <= cnt + CNT_ONE;
  end
endmodule

// File: rtl/abr_seq.sv
`timescale 1ns/1ps
module abr_seq #(
  parameter int MEAS_N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic fall,
  input  logic ovf,
  output logic en,
  output logic run,
  output logic meas_evt,
  output logic last_evt
);
  import abr_pkg::*;

  localparam int MN_W = (MEAS_N > 1) ? $clog2(MEAS_N) : 1;
  localparam logic [MN_W-1:0] MN_LAST = MN_W'(MEAS_N - 1);

  abr_state_e      st;
  logic [MN_W-1:0] mcnt;

  assign en       = (st != ABR_OFF);
  assign run      = (st == ABR_MEAS);
  assign meas_evt = run & fall;
  assign last_evt = meas_evt & (mcnt == MN_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ABR_OFF;
      mcnt <= '0;
    end else begin
      unique case (st)
        ABR_OFF:  if (arm) st <= ABR_HUNT;
        ABR_HUNT: if (fall) begin
                    st   <= ABR_MEAS;
                    mcnt <= '0;
                  end
        ABR_MEAS: if (ovf || last_evt) st <= ABR_OFF;
                  else if (meas_evt)   mcnt <= mcnt + 1'b1;
        default:  st <= ABR_OFF;
      endcase
    end
  end
endmodule

// File: rtl/abr_detector.sv
`timescale 1ns/1ps
module abr_detector #(
  parameter int          CNT_W   = 10,
  parameter int          DIV_W   = 10,
  parameter int          MEAS_N  = 4,
  parameter logic [9:0]  DIV_RST = 10'd0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx,
  input  logic               tick,
  input  logic               arm,
  input  logic               ie,
  input  logic               done_clr,
  input  logic               err_clr,
  input  logic               ival_zero,
  input  logic               div_wr,
  input  logic [DIV_W-1:0]   div_wdata,
  output logic               en,
  output logic [CNT_W-2:0]   ival,
  output logic [DIV_W-1:0]   div_out,
  output logic               done,
  output logic               err,
  output logic               irq
);
  localparam int IVAL_W = CNT_W - 1;

  // one span of the sync pattern covers two bit times
  function automatic logic [IVAL_W-1:0] bit_time(input logic [CNT_W-1:0] span);
    return span[CNT_W-1:1];
  endfunction

  function automatic logic [DIV_W-1:0] widen(input logic [IVAL_W-1:0] v);
    return DIV_W'(v);
  endfunction

  logic             fall_evt;
  logic             run;
  logic             restart;
  logic             meas_evt;
  logic             last_evt;
  logic             ovf_evt;
  logic [CNT_W-1:0] span_cnt;
  logic [IVAL_W-1:0] ival_next;

  abr_fall_detect u_fall (
    .clk  (clk),
    .rst_n(rst_n),
    .rx   (rx),
    .fall (fall_evt)
  );

  assign restart = fall_evt & en;

  abr_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (run),
    .restart(restart),
    .tick   (tick),
    .cnt    (span_cnt),
    .ovf    (ovf_evt)
  );

  abr_seq #(.MEAS_N(MEAS_N)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (arm),
    .fall    (fall_evt),
    .ovf     (ovf_evt),
    .en      (en),
    .run     (run),
    .meas_evt(meas_evt),
    .last_evt(last_evt)
  );

  assign ival_next = bit_time(span_cnt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ival    <= '0;
      div_out <= DIV_W'(DIV_RST);
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (meas_evt)       ival <= ival_next;
      else if (ival_zero) ival <= '0;

      if (last_evt)       div_out <= widen(ival_next);
      else if (div_wr)    div_out <= div_wdata;

      if (meas_evt || ovf_evt) done <= 1'b1;
      else if (done_clr)       done <= 1'b0;

      if (ovf_evt)                    err <= 1'b1;
      else if (done_clr || err_clr)   err <= 1'b0;
    end
  end

  assign irq = done & ie;
endmodule

// File: rtl/abr_detector_chk.sv
`timescale 1ns/1ps
module abr_detector_chk #(
  parameter int CNT_W = 10,
  parameter int DIV_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             done,
  input logic             err,
  input logic [CNT_W-2:0] ival,
  input logic [DIV_W-1:0] div_out,
  input logic             done_clr,
  input logic             err_clr,
  input logic             ival_zero,
  input logic             div_wr,
  input logic             meas_evt,
  input logic             last_evt,
  input logic             ovf_evt
);
  p_ovf_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (err && done && !en));

  p_ovf_div_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !div_wr) |=> $stable(div_out));

  p_ovf_ival_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !ival_zero) |=> $stable(ival));

  p_writeback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> (!en && done && div_out == DIV_W'(ival)));

  p_done_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !done_clr) |=> done);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !done_clr && !err_clr) |=> err);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !$rose(done));

  p_meas_enabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_evt |-> en);
endmodule

bind abr_detector abr_detector_chk #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .done     (done),
  .err      (err),
  .ival     (ival),
  .div_out  (div_out),
  .done_clr (done_clr),
  .err_clr  (err_clr),
  .ival_zero(ival_zero),
  .div_wr   (div_wr),
  .meas_evt (meas_evt),
  .last_evt (last_evt),
  .ovf_evt  (ovf_evt)
);

// File: tb/tb_abr_detector.sv
`timescale 1ns/1ps
module tb_abr_detector;
  localparam int CNT_W = 10;
  localparam int DIV_W = 10;

  typedef struct packed {
    logic [CNT_W-2:0] ival;
    logic             last;
    logic             err;
    logic [DIV_W-1:0] div;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1, tick = 1'b1, arm = 1'b0, ie = 1'b0;
  logic done_clr = 1'b0, err_clr = 1'b0, ival_zero = 1'b0, div_wr = 1'b0;
  logic [DIV_W-1:0] div_wdata = '0;
  logic en, done, err, irq;
  logic [CNT_W-2:0] ival;
  logic [DIV_W-1:0] div_out;

  int checks = 0;
  int errors = 0;
  bit half_tick = 1'b0;
  exp_t exp_q[$];

  abr_detector dut (
    .clk(clk), .rst_n(rst_n), .rx(rx), .tick(tick), .arm(arm), .ie(ie),
    .done_clr(done_clr), .err_clr(err_clr), .ival_zero(ival_zero),
    .div_wr(div_wr), .div_wdata(div_wdata), .en(en), .ival(ival),
    .div_out(div_out), .done(done), .err(err), .irq(irq)
  );

  initial forever #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // tick: every cycle, or every other cycle for the divided-clock case
  initial forever begin
    @(posedge clk); #1;
    tick = half_tick ? ~tick : 1'b1;
  end

  task automatic hold(input logic v, input int n);
    rx = v;
    repeat (n) @(posedge clk);
    #1;
  endtask

  // start bit, then 0x55 LSB first, then stop bit; expectations pushed first
  task automatic send_sync(input int b, input bit expect_it, input logic [DIV_W-1:0] cur_div);
    int ticks = half_tick ? b : 2 * b;
    exp_t it;
    if (expect_it) begin
      for (int k = 0; k < 4; k++) begin
        it.ival = (CNT_W-1)'(ticks / 2);
        it.last = (k == 3);
        it.err  = 1'b0;
        it.div  = (k == 3) ? DIV_W'(ticks / 2) : cur_div;
        exp_q.push_back(it);
      end
    end
    hold(1'b0, b);
    for (int d = 0; d < 8; d++) hold(((d % 2) == 0) ? 1'b1 : 1'b0, b);
    hold(1'b1, b + 8);
  endtask

  // monitor: pops one expectation per done event
  initial begin
    exp_t it;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10 unexpected done", 1, 0);
          done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
        end else begin
          it = exp_q.pop_front();
          chk(ival == it.ival, "R2 ival", int'(ival), int'(it.ival));
          chk(irq == ie, "R9 irq", int'(irq), int'(ie));
          chk(err == it.err, it.err ? "R5 err" : "R2 err", int'(err), int'(it.err));
          if (it.last) begin
            chk(en == 1'b0, "R4 en cleared", int'(en), 0);
            chk(div_out == it.div, it.err ? "R5 div kept" : "R4 div", int'(div_out), int'(it.div));
          end else begin
            chk(en == 1'b1, "R1 en held", int'(en), 1);
          end
          @(negedge clk);
          chk(done == 1'b1, "R3 sticky", int'(done), 1);
          if (it.err) begin
            err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
            chk(err == 1'b0, "R6 err_clr", int'(err), 0);
            chk(done == 1'b1, "R6 done kept", int'(done), 1);
          end
          done_clr = 1'b1; @(negedge clk); done_clr = 1'b0;
          chk(done == 1'b0, "R3 clear", int'(done), 0);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  task automatic do_arm();
    arm = 1'b1; @(posedge clk); #1; arm = 1'b0;
    @(negedge clk);
    chk(en == 1'b1, "R1 arm", int'(en), 1);
    @(posedge clk); #1;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(posedge clk);
    repeat (6) @(posedge clk);
    #1;
  endtask

  initial begin
    exp_t it;
    repeat (3) @(negedge clk);
    chk(en == 0 && done == 0 && err == 0 && irq == 0, "R1 reset flags", int'({en, done, err, irq}), 0);
    chk(ival == 0 && div_out == 0, "R1 reset values", int'(ival) + int'(div_out), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;

    // R10: idle line activity without arming
    send_sync(8, 1'b0, '0);
    chk(done == 0 && ival == 0 && div_out == 0, "R10 idle", int'(done) + int'(ival), 0);

    // R1 R2 R4 R9: full sync, tick every cycle
    ie = 1'b1;
    do_arm();
    send_sync(8, 1'b1, '0);
    drain();
    chk(div_out == 10'd8, "R4 div persists", int'(div_out), 8);

    // R11: software divider write
    div_wdata = 10'h2AA; div_wr = 1'b1; @(posedge clk); #1; div_wr = 1'b0;
    @(negedge clk);
    chk(div_out == 10'h2AA, "R11 write", int'(div_out), 'h2AA);

    // R8: tick every other cycle
    ie = 1'b0;
    half_tick = 1'b1;
    do_arm();
    send_sync(12, 1'b1, 10'h2AA);
    drain();
    half_tick = 1'b0;

    // R2 longer bit time
    ie = 1'b1;
    do_arm();
    send_sync(100, 1'b1, 10'd6);
    drain();
    chk(div_out == 10'd100, "R4 div 100", int'(div_out), 100);

    // R7: clear interval
    ival_zero = 1'b1; @(posedge clk); #1; ival_zero = 1'b0;
    @(negedge clk);
    chk(ival == 0, "R7 ival zero", int'(ival), 0);
    @(posedge clk); #1;

    // R5 R6: overrun on a long low level
    do_arm();
    it.ival = '0; it.last = 1'b1; it.err = 1'b1; it.div = 10'd100;
    exp_q.push_back(it);
    hold(1'b0, 1100);
    hold(1'b1, 20);
    drain();
    chk(en == 0, "R5 en off", int'(en), 0);

    // R10: falls after overrun are ignored
    send_sync(8, 1'b0, '0);
    @(negedge clk);
    chk(done == 0 && ival == 0, "R10 after overrun", int'(done) + int'(ival), 0);
    chk(div_out == 10'd100, "R10 div", int'(div_out), 100);
    chk(exp_q.size() == 0, "R2 all events seen", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule